// File: doc/BRIEF.md
# Prioritized Vectored Event Dispatcher

This block decides which pending event a processor core should service next and where its handler lives. Three kinds of source compete: a non-maskable interrupt, a synchronous exception request, and four levels of maskable interrupt requests. On each clock the block finds the highest-ranked eligible source. If that source outranks the handler that is running now, the block enters it. Entering means three things happen together: the block emits a one-cycle request to the core, presents the handler address, and raises its current level.

Handler addresses are a software-programmed vector base plus a fixed offset for each event. The offset table is a parameter. The low bits of the base are forced to zero, so every handler sits on an aligned boundary. Each time a handler is entered, the level that was running is saved on a small nesting stack. A return strobe from the core pops that stack and restores the saved level. The return strobe is the only stand-in for the core's own context save and restore.

Top module: `vec_exc_ctrl`

## Requirements
- R1: After reset, `cur_level` is 0, `req_pulse` and `stack_err` are low, `vec_addr` is 0, and the vector base is 0.
- R2: When several sources are eligible in the same cycle, the winner is ranked as follows: non-maskable interrupt first, then the exception request, then interrupt level 3, 2, 1 and 0.
- R3: Levels are encoded as follows: 0 = thread, 1..4 = interrupt levels 0..3, 5 = exception, 6 = non-maskable. An event is entered only when its level is strictly greater than `cur_level`. Without an entry or a return, `cur_level` holds.
- R4: Interrupt level n is eligible only when `irq_req[n]` is high, `irq_mask[n]` is low and `glob_mask` is low. The exception request and the non-maskable interrupt ignore both masks.
- R5: On entry, `vec_addr` equals the aligned base plus the event's offset. The default offsets are: non-maskable 0x000, exception 0x010, interrupt level 0/1/2/3 0x040/0x044/0x048/0x04C. `vec_addr` holds between entries.
- R6: A cycle with `base_we` high loads `base_wdata` with its low 8 bits cleared. The new base applies to entries from the following cycle onward.
- R7: Entry drives `req_pulse` high for exactly that one cycle. In the same cycle, `cur_level` takes the new level and the old level is pushed on the nesting stack, which holds 6 entries.
- R8: `ret_strobe` with a non-empty stack restores `cur_level` to the most recently pushed level. No entry is made in a cycle in which `ret_strobe` is high.
- R9: `ret_strobe` with an empty stack raises `stack_err` for one cycle and leaves `cur_level` unchanged.
- R10: The non-maskable interrupt is taken on a rising edge of `nmi_req`. Holding it high does not re-enter it. A rising edge that arrives while its handler runs is remembered and entered after the return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req | input | 1 | Non-maskable interrupt, edge detected |
| exc_req | input | 1 | Synchronous exception request, level |
| irq_req | input | 4 | Interrupt requests, bit n = level n |
| irq_mask | input | 4 | Per-level interrupt mask, 1 = masked |
| glob_mask | input | 1 | Global interrupt mask, 1 = all levels masked |
| base_we | input | 1 | Vector base write strobe |
| base_wdata | input | 32 | Vector base write data |
| ret_strobe | input | 1 | Return from handler |
| req_pulse | output | 1 | One-cycle handler entry request |
| vec_addr | output | 32 | Handler address of the last entry |
| cur_level | output | 3 | Level now executing |
| stack_err | output | 1 | Return with empty nesting stack |

## Verification
The hardest situation to reach from the ports is the full nesting chain. To get there, thread, all four interrupt levels, the exception and the non-maskable interrupt must be entered in strictly rising order, with no return in between. On top of that, a second non-maskable edge must arrive while the first handler still runs. A directed sequence builds this chain step by step. It toggles `nmi_req` inside the top handler, then unwinds with returns, including one extra return that empties the stack. Random cycles then mix sparse exception and non-maskable events with dense interrupt traffic and frequent returns, so that nesting depth keeps rising and falling around masked and unmasked levels.

// File: rtl/vec_exc_pkg.sv
package vec_exc_pkg;
  localparam int unsigned NUM_IRQ_LVL = 4;
  localparam int unsigned NUM_EVT     = NUM_IRQ_LVL + 2;
  localparam int unsigned LVL_W       = $clog2(NUM_EVT + 1);
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_THREAD = '0;
  localparam lvl_t LVL_EXC    = lvl_t'(NUM_IRQ_LVL + 1);
  localparam lvl_t LVL_NMI    = lvl_t'(NUM_IRQ_LVL + 2);
endpackage

// File: rtl/vec_prio_sel.sv
module vec_prio_sel
  import vec_exc_pkg::*;
(
  input  logic                   nmi_c,
  input  logic                   exc_c,
  input  logic [NUM_IRQ_LVL-1:0] irq_c,
  input  lvl_t                   cur_lvl,
  output logic                   fire,
  output lvl_t                   win_lvl
);
  // later assignments win: lowest rank first, highest rank last
  always_comb begin
    win_lvl = LVL_THREAD;
    for (int i = 0; i < NUM_IRQ_LVL; i++) begin
      if (irq_c[i]) win_lvl = lvl_t'(i + 1);
    end
    if (exc_c) win_lvl = LVL_EXC;
    if (nmi_c) win_lvl = LVL_NMI;
    fire = (win_lvl > cur_lvl);
  end
endmodule

// File: rtl/vec_nest_stack.sv
module vec_nest_stack #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] top,
  output logic         empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             do_push, do_pop;

  always_comb begin
    do_push = push && (ptr_q != PTR_MAX);
    do_pop  = pop && (ptr_q != '0);
    ptr_n   = ptr_q;
    if (do_push)     ptr_n = ptr_q + 1'b1;
    else if (do_pop) ptr_n = ptr_q - 1'b1;
    empty = (ptr_q == '0);
    top   = empty ? '0 : mem_q[ptr_q - 1'b1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[ptr_q] <= push_data;
  end
endmodule

// File: rtl/vec_exc_ctrl.sv
module vec_exc_ctrl
  import vec_exc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned ALIGN_BITS  = 8,
  parameter int unsigned STACK_DEPTH = 6,
  parameter logic [NUM_EVT-1:0][15:0] VEC_OFS =
    {16'h0000, 16'h0010, 16'h004C, 16'h0048, 16'h0044, 16'h0040}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nmi_req,
  input  logic                   exc_req,
  input  logic [NUM_IRQ_LVL-1:0] irq_req,
  input  logic [NUM_IRQ_LVL-1:0] irq_mask,
  input  logic                   glob_mask,
  input  logic                   base_we,
  input  logic [ADDR_W-1:0]      base_wdata,
  input  logic                   ret_strobe,
  output logic                   req_pulse,
  output logic [ADDR_W-1:0]      vec_addr,
  output logic [LVL_W-1:0]       cur_level,
  output logic                   stack_err
);
  localparam int unsigned IDX_W = $clog2(NUM_EVT);

  logic              nmi_d_q, nmi_pend_q, nmi_pend_n;
  logic [ADDR_W-1:0] base_q, base_n, vec_q, vec_n;
  lvl_t              lvl_q, lvl_n;
  logic              req_q, err_q;
  logic              nmi_rise, nmi_c, fire, take, pop_ok;
  logic [NUM_IRQ_LVL-1:0] irq_c;
  lvl_t              win_lvl, stk_top;
  logic              stk_empty;
  logic [IDX_W-1:0]  ofs_idx;

  always_comb begin
    nmi_rise = nmi_req & ~nmi_d_q;
    nmi_c    = nmi_pend_q | nmi_rise;
    irq_c    = irq_req & ~irq_mask & {NUM_IRQ_LVL{~glob_mask}};
  end

  vec_prio_sel u_sel (
    .nmi_c   (nmi_c),
    .exc_c   (exc_c_w),
    .irq_c   (irq_c),
    .cur_lvl (lvl_q),
    .fire    (fire),
    .win_lvl (win_lvl)
  );

  logic exc_c_w;
  assign exc_c_w = exc_req;

  vec_nest_stack #(.DEPTH(STACK_DEPTH), .W(LVL_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (take),
    .push_data (lvl_q),
    .pop       (pop_ok),
    .top       (stk_top),
    .empty     (stk_empty)
  );

  always_comb begin
    take       = fire & ~ret_strobe;
    pop_ok     = ret_strobe & ~stk_empty;
    ofs_idx    = (win_lvl == LVL_THREAD) ? '0 : IDX_W'(win_lvl - 1'b1);
    lvl_n      = take ? win_lvl : (pop_ok ? stk_top : lvl_q);
    vec_n      = take ? (base_q + ADDR_W'(VEC_OFS[ofs_idx])) : vec_q;
    base_n     = base_we ? {base_wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}} : base_q;
    nmi_pend_n = nmi_c & ~(take && (win_lvl == LVL_NMI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d_q    <= 1'b0;
      nmi_pend_q <= 1'b0;
      base_q     <= '0;
      vec_q      <= '0;
      lvl_q      <= LVL_THREAD;
      req_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      nmi_d_q    <= nmi_req;
      nmi_pend_q <= nmi_pend_n;
      if (base_we) base_q <= base_n;
      if (take)    vec_q  <= vec_n;
      if (take || pop_ok) lvl_q <= lvl_n;
      req_q      <= take;
      err_q      <= ret_strobe & stk_empty;
    end
  end

  assign req_pulse = req_q;
  assign vec_addr  = vec_q;
  assign cur_level = lvl_q;
  assign stack_err = err_q;
endmodule

// File: rtl/vec_exc_ctrl_chk.sv
module vec_exc_ctrl_chk
  import vec_exc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       nmi_req,
  input logic       ret_strobe,
  input logic       req_pulse,
  input logic [LVL_W-1:0] cur_level,
  input logic       stack_err
);
  logic nmi_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_prev <= 1'b0;
    else        nmi_prev <= nmi_req;
  end

  p_entry_raises_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> (cur_level > $past(cur_level)));

  p_ret_blocks_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_strobe |=> !req_pulse);

  p_underflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |-> ($past(ret_strobe) && (cur_level == LVL_THREAD)));

  p_level_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_pulse && !$past(ret_strobe)) |-> $stable(cur_level));

  p_nmi_edge_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !nmi_prev && !ret_strobe && (cur_level != LVL_NMI))
      |=> (req_pulse && (cur_level == LVL_NMI)));
endmodule

bind vec_exc_ctrl vec_exc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_req    (nmi_req),
  .ret_strobe (ret_strobe),
  .req_pulse  (req_pulse),
  .cur_level  (cur_level),
  .stack_err  (stack_err)
);

// File: tb/vec_exc_ctrl_tb.sv
module vec_exc_ctrl_tb;
  logic        clk, rst_n;
  logic        nmi_req, exc_req, glob_mask, base_we, ret_strobe;
  logic [3:0]  irq_req, irq_mask;
  logic [31:0] base_wdata;
  logic        req_pulse, stack_err;
  logic [31:0] vec_addr;
  logic [2:0]  cur_level;

  int n_run, n_fail;
  bit done;

  // bench model state
  int          m_lvl, m_sp;
  int          m_stk [8];
  logic [31:0] m_base, m_vec;
  bit          m_nmi_d, m_nmi_pend;
  bit          e_req, e_err;

  vec_exc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .exc_req(exc_req),
    .irq_req(irq_req), .irq_mask(irq_mask), .glob_mask(glob_mask),
    .base_we(base_we), .base_wdata(base_wdata), .ret_strobe(ret_strobe),
    .req_pulse(req_pulse), .vec_addr(vec_addr), .cur_level(cur_level),
    .stack_err(stack_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ofs(int lvl);
    case (lvl)
      6: return 32'h000;
      5: return 32'h010;
      4: return 32'h04C;
      3: return 32'h048;
      2: return 32'h044;
      default: return 32'h040;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // called just after a negedge with inputs set; ends at next negedge
  task automatic step();
    bit rise, nc, take;
    int win;
    rise = nmi_req && !m_nmi_d;
    nc   = m_nmi_pend || rise;
    win  = 0;
    for (int i = 0; i < 4; i++)
      if (irq_req[i] && !irq_mask[i] && !glob_mask) win = i + 1;
    if (exc_req) win = 5;
    if (nc) win = 6;
    take  = (win > m_lvl) && !ret_strobe;
    e_req = take;
    e_err = ret_strobe && (m_sp == 0);
    if (take) begin
      m_vec = m_base + ofs(win);
      m_stk[m_sp] = m_lvl;
      m_sp++;
      m_lvl = win;
    end else if (ret_strobe && m_sp > 0) begin
      m_sp--;
      m_lvl = m_stk[m_sp];
    end
    m_nmi_pend = nc && !(take && win == 6);
    m_nmi_d    = nmi_req;
    if (base_we) m_base = {base_wdata[31:8], 8'h00};
    @(posedge clk);
    #1;
    chk("R7 req_pulse", {31'b0, req_pulse}, {31'b0, e_req});
    chk("R3 cur_level", {29'b0, cur_level}, 32'(m_lvl));
    chk("R9 stack_err", {31'b0, stack_err}, {31'b0, e_err});
    chk("R5 vec_addr", vec_addr, m_vec);
    @(negedge clk);
    ret_strobe = 1'b0;
    base_we    = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    n_run = 0; n_fail = 0; done = 0;
    m_lvl = 0; m_sp = 0; m_base = '0; m_vec = '0; m_nmi_d = 0; m_nmi_pend = 0;
    rst_n = 1'b0; nmi_req = 0; exc_req = 0; glob_mask = 0; base_we = 0;
    ret_strobe = 0; irq_req = '0; irq_mask = '0; base_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 level", {29'b0, cur_level}, 32'd0);
    chk("R1 req", {31'b0, req_pulse}, 32'd0);
    chk("R1 err", {31'b0, stack_err}, 32'd0);
    chk("R1 vec", vec_addr, 32'd0);

    // R9 return with empty stack
    ret_strobe = 1; step();
    chk("R9 err pulse", {31'b0, stack_err}, 32'd1);
    step();
    chk("R9 err one cycle", {31'b0, stack_err}, 32'd0);

    // R6 base write with alignment
    base_we = 1; base_wdata = 32'h1234_56FF; step();
    // R2 level 2 beats level 0
    irq_req = 4'b0101; step();
    chk("R2 winner level", {29'b0, cur_level}, 32'd3);
    chk("R6 aligned vector", vec_addr, 32'h1234_5648);
    // R4 masked level 3 ignored
    irq_req = 4'b1111; irq_mask = 4'b1000; step();
    chk("R4 masked no entry", {31'b0, req_pulse}, 32'd0);
    // R4 global mask, exception still taken
    irq_mask = 4'b0000; glob_mask = 1; exc_req = 1; step();
    chk("R4 exception unmasked", {29'b0, cur_level}, 32'd5);
    // R10 NMI through masks
    nmi_req = 1; step();
    chk("R10 nmi entry", vec_addr, 32'h1234_5600);
    step(); step();
    chk("R10 held nmi no retrigger", {31'b0, req_pulse}, 32'd0);
    nmi_req = 0; step();
    nmi_req = 1; step();
    chk("R10 second nmi blocked", {29'b0, cur_level}, 32'd6);
    // R8 return pops to exception, no entry that cycle
    ret_strobe = 1; step();
    chk("R8 pop level", {29'b0, cur_level}, 32'd5);
    chk("R8 no entry on return", {31'b0, req_pulse}, 32'd0);
    step();
    chk("R10 remembered nmi entered", {29'b0, cur_level}, 32'd6);
    // unwind fully, then one extra return
    nmi_req = 0; exc_req = 0; irq_req = '0; glob_mask = 0;
    for (int k = 0; k < 5; k++) begin ret_strobe = 1; step(); end
    chk("R8 back to thread", {29'b0, cur_level}, 32'd0);
    ret_strobe = 1; step();
    chk("R9 extra return", {31'b0, stack_err}, 32'd1);

    // R2 full chain: rising levels 1..4 then exception then nmi
    for (int k = 0; k < 4; k++) begin irq_req[k] = 1; step(); end
    chk("R2 top interrupt", {29'b0, cur_level}, 32'd4);
    exc_req = 1; step();
    nmi_req = 1; step();
    chk("R7 depth six", {29'b0, cur_level}, 32'd6);
    nmi_req = 0; exc_req = 0; irq_req = '0;
    for (int k = 0; k < 7; k++) begin ret_strobe = 1; step(); end

    // random phase
    for (int c = 0; c < 4000; c++) begin
      irq_req    = 4'($urandom);
      irq_mask   = ($urandom % 4 == 0) ? 4'($urandom) : 4'b0000;
      glob_mask  = ($urandom % 8 == 0);
      exc_req    = ($urandom % 16 == 0);
      if ($urandom % 24 == 0) nmi_req = ~nmi_req;
      ret_strobe = ($urandom % 3 == 0);
      base_we    = ($urandom % 64 == 0);
      base_wdata = $urandom;
      step();
    end
    finish_run();
  end
endmodule